// File: doc/BRIEF.md
# Board strap revision detector

This block finds out which spare device pins are shorted, on the circuit board, to one common driver pin. Logic can then adapt to the board revision without a new device image. After reset the block runs a counted detection window. In each detection cycle it first drives every sense line low and releases the driver line. It then drives the driver line high and releases the sense lines. Each sense input is registered and compared with the level expected for that phase. A pin strapped to the driver follows the square wave. A pin left open reads low in both phases, because it was just driven low and its pad capacitance holds the level, so it fails the high-phase compare.

The block never drives a pad. It supplies the driver level and one output enable for the driver pad and one for the sense pads, and the tri-state buffers are placed at chip level. The window length is 2^`CNT_W` detection cycles, each two clocks long. There are `CHANNELS` sense inputs, with one result bit per input. When the window ends, `done` rises and the result bits freeze until the next reset. The result bits are valid only while `done` is high.

Top module: `strap_probe`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block goes after that edge to this state: `done` low, every `match` bit 1, `drv_oe` and `drv_out` low, `sense_oe` high.
- R2: During the window the clock cycles alternate, starting with the low phase right after reset. The low phase has `drv_oe`=0, `drv_out`=0 and `sense_oe`=1. The high phase has `drv_oe`=1, `drv_out`=1 and `sense_oe`=0. `drv_oe` and `sense_oe` are never both high.
- R3: `done` rises after exactly 2·2^`CNT_W`+1 rising edges with `rst` low. This is one sampling edge per phase plus one edge for the final comparison.
- R4: A `match` bit stays 1 when its input read the expected level (0 in the low phase, 1 in the high phase) at every sampling edge of the window. An open input that reads low while released ends with 0.
- R5: A single wrong sample on a channel, in either phase, including the first and the last sample of the window, clears that channel's `match` bit. The bit stays 0 for the rest of the window even when later samples are correct.
- R6: The sense level in the clock cycle after the last sampled phase (the tail cycle) has no effect on `match`.
- R7: Once `done` is high, `done` and `match` hold until reset whatever the sense inputs do. `drv_oe` stays 0 and `sense_oe` stays 1.
- R8: A reset in the middle of a window drops the partial result and starts a complete new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_in | input | CHANNELS | Levels read from the sense pads |
| drv_out | output | 1 | Level for the driver pad |
| drv_oe | output | 1 | Output enable of the driver pad buffer |
| sense_oe | output | 1 | Output enable of all sense pad buffers (they drive low) |
| match | output | CHANNELS | Per-channel result: 1 means strapped to the driver |
| done | output | 1 | Window finished; `match` is valid |

## Verification
A sense level present before edge k+1 is captured at that edge. It is folded into `match` one edge later, so a wrong sample shows on `match` two edges after it is presented. `done` is due after edge 2·2^`CNT_W`+1. The bench resolves the board wiring from the block's own enables. It keeps a reference of the edge count, the pending sample and the sticky mismatch vector, and advances that reference once per clock. At every falling edge it compares all outputs with the reference, so every result is checked in the cycle it falls due. Extra end-of-case checks cover the first-sample, last-sample, tail-cycle, hold and mid-run reset cases.

// File: rtl/strap_probe.sv
module strap_probe #(
  parameter int CHANNELS = 4,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] sense_in,
  output logic                drv_out,
  output logic                drv_oe,
  output logic                sense_oe,
  output logic [CHANNELS-1:0] match,
  output logic                done
);

  localparam int HALF_W = CNT_W + 2;
  localparam logic [HALF_W-1:0] TAIL = {2'b10, {CNT_W{1'b0}}};

  logic [HALF_W-1:0]   half_cnt;
  logic [CHANNELS-1:0] sense_q;
  logic [CHANNELS-1:0] miss;
  logic                exp_q;
  logic                cmp_q;
  logic                sampling;

  assign sampling = !done && (half_cnt != TAIL);
  assign drv_oe   = sampling && half_cnt[0];
  assign drv_out  = drv_oe;
  assign sense_oe = !drv_oe;
  assign match    = ~miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_cnt <= '0;
      done     <= 1'b0;
      miss     <= '0;
      sense_q  <= '0;
      exp_q    <= 1'b0;
      cmp_q    <= 1'b0;
    end else begin
      sense_q <= sense_in;
      exp_q   <= half_cnt[0];
      cmp_q   <= sampling;
      if (cmp_q)
        miss <= miss | (sense_q ^ {CHANNELS{exp_q}});
      if (!done) begin
        half_cnt <= half_cnt + 1'b1;
        if (half_cnt == TAIL)
          done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/strap_probe_chk.sv
module strap_probe_chk #(
  parameter int CHANNELS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                drv_out,
  input logic                drv_oe,
  input logic                sense_oe,
  input logic [CHANNELS-1:0] match,
  input logic                done
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!done && (&match) && !drv_oe && sense_oe));

  assert_no_contention_R2: assert property (@(posedge clk) disable iff (rst)
    !(drv_oe && sense_oe));

  assert_driver_level_R2: assert property (@(posedge clk) disable iff (rst)
    drv_out == drv_oe);

  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (drv_oe && !done) |=> !drv_oe);

  assert_match_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((match & ~$past(match)) == '0));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(match)));

  assert_idle_pads_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!drv_oe && sense_oe));

endmodule

bind strap_probe strap_probe_chk #(.CHANNELS(CHANNELS)) u_strap_probe_chk (
  .clk     (clk),
  .rst     (rst),
  .drv_out (drv_out),
  .drv_oe  (drv_oe),
  .sense_oe(sense_oe),
  .match   (match),
  .done    (done)
);

// File: tb/strap_probe_bench.sv
module strap_probe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CH  = 4;
  localparam int CW  = 3;
  localparam int WIN = 2 * (1 << CW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CH-1:0] strap = '0;
  logic [CH-1:0] flt   = '0;
  logic [CH-1:0] glt   = '0;
  logic [CH-1:0] sense_in;
  logic drv_out, drv_oe, sense_oe, done;
  logic [CH-1:0] match;

  int checks = 0;
  int errors = 0;

  int            k = 0;
  logic [CH-1:0] miss = '0;
  logic [CH-1:0] pend_s = '0;
  logic          pend_e = 1'b0;
  logic          pend_v = 1'b0;
  logic          last_rst = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar i = 0; i < CH; i++) begin : g_board
    assign sense_in[i] = glt[i] ^ (strap[i] ? (drv_oe ? drv_out : 1'b0)
                                            : (sense_oe ? 1'b0 : flt[i]));
  end

  strap_probe #(.CHANNELS(CH), .CNT_W(CW)) u_strap_probe (
    .clk(clk), .rst(rst), .sense_in(sense_in), .drv_out(drv_out),
    .drv_oe(drv_oe), .sense_oe(sense_oe), .match(match), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at time %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    bit e_done, e_oe;
    e_done = (k >= WIN + 1);
    e_oe   = !e_done && (k < WIN) && (k % 2 == 1);
    if (last_rst) begin
      check(done == 1'b0 && match == '1 && !drv_oe && !drv_out && sense_oe, "R1 reset state",
            {done, match, drv_oe, drv_out, sense_oe}, {1'b0, {CH{1'b1}}, 3'b001});
    end else begin
      check(done == e_done, "R3 done timing", done, e_done);
      check(drv_oe == e_oe && drv_out == e_oe && sense_oe == !e_oe,
            e_done ? "R7 pad enables" : "R2 pad enables",
            {drv_oe, drv_out, sense_oe}, {e_oe, e_oe, !e_oe});
      check(match == ~miss, e_done ? "R7 match hold" : "R4 match", match, ~miss);
    end
  endtask

  task automatic step(input logic r, input logic [CH-1:0] gmask);
    @(negedge clk);
    check_outputs();
    glt = gmask;
    rst = r;
    #1;
    if (r) begin
      k = 0; miss = '0; pend_v = 1'b0;
    end else begin
      if (pend_v) miss = miss | (pend_s ^ {CH{pend_e}});
      pend_v = (k < WIN);
      pend_s = sense_in;
      pend_e = k[0];
      k++;
    end
    last_rst = r;
  endtask

  task automatic run_case(input logic [CH-1:0] s, input int gk1, input logic [CH-1:0] m1,
                          input int gk2, input logic [CH-1:0] m2, input int extra,
                          input logic [CH-1:0] hold_mask, input logic [CH-1:0] exp_final,
                          input string tag);
    strap = s;
    step(1'b1, '0);
    step(1'b1, '0);
    for (int c = 0; c < WIN + 1; c++)
      step(1'b0, ((k == gk1) ? m1 : '0) | ((k == gk2) ? m2 : '0));
    for (int c = 0; c < extra; c++)
      step(1'b0, hold_mask);
    step(1'b0, '0);
    check(done == 1'b1 && match == exp_final, tag, {done, match}, {1'b1, exp_final});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    flt = '0;
    // R4: two strapped, two open channels
    run_case(4'b0101, -1, '0, -1, '0, 0, '0, 4'b0101, "R4 strapped pattern");
    // R5: high-phase glitch on ch2 at k=5, low-phase glitch on ch0 at k=10
    run_case(4'b1111, 5, 4'b0100, 10, 4'b0001, 0, '0, 4'b1010, "R5 sticky mismatch");
    // R5: glitch on first sample (ch1) and last sample (ch3)
    run_case(4'b1111, 0, 4'b0010, WIN - 1, 4'b1000, 0, '0, 4'b0101, "R5 first and last sample");
    // R6: disturbance only in the tail cycle is ignored
    run_case(4'b0101, WIN, 4'b1111, -1, '0, 0, '0, 4'b0101, "R6 tail cycle ignored");
    // R7: sense lines toggling after done change nothing
    run_case(4'b0110, -1, '0, -1, '0, 10, 4'b1111, 4'b0110, "R7 hold after done");
    // R8: mid-run reset after a glitch, then a clean run
    strap = 4'b1111;
    step(1'b1, '0);
    for (int c = 0; c < 7; c++) step(1'b0, (k == 3) ? 4'b0001 : '0);
    step(1'b1, '0);
    step(1'b0, '0);
    check(done == 1'b0 && match == 4'b1111, "R8 partial result dropped", {done, match}, {1'b0, 4'b1111});
    for (int c = 0; c < WIN + 2; c++) step(1'b0, '0);
    check(done == 1'b1 && match == 4'b1111, "R8 rerun result", {done, match}, {1'b1, 4'b1111});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule